// File: doc/BRIEF.md
# Dual-line latched interrupt controller

This block gathers a set of event sources into two interrupt lines. Every source has a raw bit. A parameter makes each raw bit either level-type or edge-type. A level-type raw bit mirrors its input directly. An edge-type raw bit captures a single-cycle pulse and holds it until software clears it. Each source also has a sticky pending (status) flag, one enable per output line, and a write-one-to-clear strobe.

A pending flag can only be set while at least one of its two enables is on. It is set when the raw bit changes state, in either direction. Output line A is high while any pending flag whose A enable is on is set. Output line B works the same way with the B enables. A source with both enables on drives both lines.

Each pending flag is a two-state machine, `CELL_IDLE` and `CELL_PEND`:
- `IDLE->PEND` is taken on an armed raw change.
- `PEND->IDLE` is taken on a clear strobe, unless an armed change arrives in the same cycle.
- A source with neither enable on still leaves `IDLE` only through `IDLE->PEND`, and that transition needs an enable, so the source stays idle.

Software uses a simple register port. Writes take effect at the clock edge. Reads are combinational from the read address.

Register addresses:

| Address | Register | Access |
|---|---|---|
| 0 | raw | read only |
| 1 | pending | read only |
| 2 | line-A enables | read/write |
| 3 | line-B enables | read/write |
| 4 | clear | write only, reads as 0 |

Top module: `irq_dual_ctrl`

## Requirements
- R1: After reset, the raw, pending, line-A enable and line-B enable registers all read 0, and `irq_a` and `irq_b` are low.
- R2: For a level-type source (bit clear in `EDGE_SEL`), raw bit i at address 0 equals `src_in[i]` once a clock edge has passed.
- R3: For an edge-type source (bit set in `EDGE_SEL`), a one-cycle high on `src_in[i]` sets raw bit i. The bit stays 1, whatever the input does, until a clear write to bit i.
- R4: When raw bit i changes state, in either direction, and either enable bit i is set, pending bit i (address 1) reads 1 from the edge that sampled the change onwards.
- R5: A raw change on a source whose two enable bits are both 0 leaves its pending bit at 0.
- R6: A pending bit stays 1 until a write of 1 to that bit at address 4. Such a write clears the pending bit. For an edge-type source it also clears the raw bit. For a level-type source it leaves the raw bit unchanged.
- R7: If an armed raw change and a clear write for the same bit fall in the same cycle, the pending bit stays 1.
- R8: `irq_a` is high exactly when some pending bit has its line-A enable bit set, and `irq_b` likewise with the line-B enables. Turning an enable off drops the line but keeps the pending bit.
- R9: Addresses 2 and 3 read back the last value written to them. Address 4 always reads 0.
- R10: A pending bit and the output lines update at the same clock edge that samples the source change. There is no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| src_in | input | NUM_SRC | Per-source event pulse (edge-type) or condition level (level-type) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | NUM_SRC | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | NUM_SRC | Combinational read data |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The bench builds the block with its defaults: eight sources with `EDGE_SEL` = 0xF0. This gives four level-type sources (bits 0 to 3) and four edge-type sources (bits 4 to 7), so both raw flavours and both clear behaviours are covered in one build.

Line A is enabled for the low nibble and line B for the high nibble. Bit 3 is later enabled on both lines, which covers single-line routing, dual-line routing and the effect of turning an enable off. A falling level input and a clear write in the same cycle cover the collision case.

// File: rtl/irq_dual_pkg.sv
package irq_dual_pkg;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_PEND = 1'b1
    } cell_state_e;

    localparam int unsigned REG_RAW    = 0;
    localparam int unsigned REG_STATUS = 1;
    localparam int unsigned REG_MASK_A = 2;
    localparam int unsigned REG_MASK_B = 3;
    localparam int unsigned REG_CLEAR  = 4;

endpackage

// File: rtl/irq_raw_stage.sv
module irq_raw_stage #(
    parameter int unsigned         NUM_SRC  = 8,
    parameter logic [NUM_SRC-1:0]  EDGE_SEL = 8'hF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] raw,
    output logic [NUM_SRC-1:0] change
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (EDGE_SEL[i]) begin : g_edge
            logic held_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    held_q <= 1'b0;
                end else if (src_in[i]) begin
                    held_q <= 1'b1;          // a new event beats a clear
                end else if (clr_vec[i]) begin
                    held_q <= 1'b0;
                end
            end

            assign raw[i]    = held_q;
            assign change[i] = src_in[i] & ~held_q;
        end else begin : g_level
            logic prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                end else begin
                    prev_q <= src_in[i];
                end
            end

            assign raw[i]    = src_in[i];
            assign change[i] = src_in[i] ^ prev_q;
        end
    end

endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell
    import irq_dual_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic armed,
    input  logic clr,
    output logic pending
);

    cell_state_e state_q;
    cell_state_e state_d;
    logic        hit;

    assign hit = change & armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: if (hit)          state_d = CELL_PEND;
            CELL_PEND: if (clr && !hit)  state_d = CELL_IDLE;
            default:                     state_d = CELL_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == CELL_PEND);
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_dual_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] mask_a,
    output logic [NUM_SRC-1:0] mask_b,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(REG_RAW);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK_A = ADDR_W'(REG_MASK_A);
    localparam logic [ADDR_W-1:0] A_MASK_B = ADDR_W'(REG_MASK_B);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(REG_CLEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_a <= '0;
            mask_b <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MASK_A) mask_a <= wr_data;
            if (wr_addr == A_MASK_B) mask_b <= wr_data;
        end
    end

    always_comb begin
        clr_vec = (wr_en && (wr_addr == A_CLEAR)) ? wr_data : '0;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_RAW:    rd_data = raw;
            A_STATUS: rd_data = status;
            A_MASK_A: rd_data = mask_a;
            A_MASK_B: rd_data = mask_b;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_dual_ctrl.sv
module irq_dual_ctrl #(
    parameter int unsigned         NUM_SRC  = 8,
    parameter int unsigned         ADDR_W   = 3,
    parameter logic [NUM_SRC-1:0]  EDGE_SEL = 8'hF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [NUM_SRC-1:0] rd_data,
    output logic               irq_a,
    output logic               irq_b
);

    logic [NUM_SRC-1:0] raw_vec;
    logic [NUM_SRC-1:0] change_vec;
    logic [NUM_SRC-1:0] status_vec;
    logic [NUM_SRC-1:0] mask_a;
    logic [NUM_SRC-1:0] mask_b;
    logic [NUM_SRC-1:0] clr_vec;

    irq_raw_stage #(
        .NUM_SRC  (NUM_SRC),
        .EDGE_SEL (EDGE_SEL)
    ) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .clr_vec (clr_vec),
        .raw     (raw_vec),
        .change  (change_vec)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        irq_status_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .change  (change_vec[i]),
            .armed   (mask_a[i] | mask_b[i]),
            .clr     (clr_vec[i]),
            .pending (status_vec[i])
        );
    end

    irq_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .raw     (raw_vec),
        .status  (status_vec),
        .mask_a  (mask_a),
        .mask_b  (mask_b),
        .clr_vec (clr_vec),
        .rd_data (rd_data)
    );

    always_comb begin
        irq_a = |(status_vec & mask_a);
        irq_b = |(status_vec & mask_b);
    end

endmodule

// File: rtl/irq_dual_ctrl_chk.sv
module irq_dual_ctrl_chk
    import irq_dual_pkg::*;
#(
    parameter int unsigned         NUM_SRC  = 8,
    parameter int unsigned         ADDR_W   = 3,
    parameter logic [NUM_SRC-1:0]  EDGE_SEL = 8'hF0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_in,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NUM_SRC-1:0] wr_data,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [NUM_SRC-1:0] rd_data,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] mask_a,
    input logic [NUM_SRC-1:0] mask_b
);

    logic [NUM_SRC-1:0] clr_seen;

    always_comb begin
        clr_seen = (wr_en && (wr_addr == ADDR_W'(REG_CLEAR))) ? wr_data : '0;
    end

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(REG_CLEAR)) |-> (rd_data == '0)); // R9

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) & ~($past(mask_a) | $past(mask_b))) == '0); // R5

    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status) & ~$past(clr_seen)) == '0); // R6

    AST_EDGE_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw) & ~raw) & EDGE_SEL & ~$past(clr_seen)) == '0); // R3

    AST_EDGE_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_in & EDGE_SEL) != '0) |=>
        ((raw & $past(src_in) & EDGE_SEL) == ($past(src_in) & EDGE_SEL))); // R3

endmodule

bind irq_dual_ctrl irq_dual_ctrl_chk #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .EDGE_SEL (EDGE_SEL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (src_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .raw     (raw_vec),
    .status  (status_vec),
    .mask_a  (mask_a),
    .mask_b  (mask_b)
);

// File: tb/irq_dual_ctrl_bench.sv
module irq_dual_ctrl_bench;

    localparam int unsigned NUM_SRC = 8;
    localparam int unsigned ADDR_W  = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_in = '0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [NUM_SRC-1:0] wr_data = '0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [NUM_SRC-1:0] rd_data;
    logic               irq_a;
    logic               irq_b;

    typedef struct {
        logic [ADDR_W-1:0]  addr;
        logic [NUM_SRC-1:0] data;
        logic               ia;
        logic               ib;
        string              tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_dual_ctrl u_irq_dual_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_a   (irq_a),
        .irq_b   (irq_b)
    );

    // monitor: samples mid-cycle, well away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (rd_data !== it.data || irq_a !== it.ia || irq_b !== it.ib) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d actual data=%02h a=%b b=%b expected data=%02h a=%b b=%b",
                             it.tag, it.addr, rd_data, irq_a, irq_b, it.data, it.ia, it.ib);
                end
            end
        end
    end

    task automatic expect_rd(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d,
                             input logic ea, input logic eb, input string tag);
        exp_item_t it;
        rd_addr = a;
        it.addr = a; it.data = d; it.ia = ea; it.ib = eb; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_src(input int idx, input logic v);
        src_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic pulse_src(input int idx);
        src_in[idx] = 1'b1;
        @(negedge clk);
        src_in[idx] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        expect_rd(0, 8'h00, 0, 0, "R1 raw");
        expect_rd(1, 8'h00, 0, 0, "R1 pending");
        expect_rd(2, 8'h00, 0, 0, "R1 enable A");
        expect_rd(3, 8'h00, 0, 0, "R1 enable B");

        // no enables: raw moves, pending stays 0
        set_src(0, 1'b1);
        expect_rd(0, 8'h01, 0, 0, "R2 level raw follows");
        expect_rd(1, 8'h00, 0, 0, "R5 no enable, no pending");
        pulse_src(4);
        expect_rd(0, 8'h11, 0, 0, "R3 edge raw latched");
        expect_rd(0, 8'h11, 0, 0, "R3 edge raw still held");
        expect_rd(1, 8'h00, 0, 0, "R5 edge without enable");
        reg_wr(4, 8'h10);
        expect_rd(0, 8'h01, 0, 0, "R6 clear drops edge raw");
        set_src(0, 1'b0);
        expect_rd(0, 8'h00, 0, 0, "R2 level raw low");

        // enables
        reg_wr(2, 8'h0F);
        reg_wr(3, 8'hF0);
        expect_rd(2, 8'h0F, 0, 0, "R9 enable A readback");
        expect_rd(3, 8'hF0, 0, 0, "R9 enable B readback");
        expect_rd(4, 8'h00, 0, 0, "R9 clear reads zero");

        // level rise on line A
        set_src(1, 1'b1);
        expect_rd(1, 8'h02, 1, 0, "R10 pending on sampling edge");
        expect_rd(0, 8'h02, 1, 0, "R4 raw of level rise");
        reg_wr(4, 8'h02);
        expect_rd(1, 8'h00, 0, 0, "R6 pending cleared");
        expect_rd(0, 8'h02, 0, 0, "R6 level raw kept");
        set_src(1, 1'b0);
        expect_rd(1, 8'h02, 1, 0, "R4 falling change sets pending");
        reg_wr(4, 8'h02);
        expect_rd(1, 8'h00, 0, 0, "R6 pending cleared again");

        // edge source on line B
        pulse_src(5);
        expect_rd(1, 8'h20, 0, 1, "R8 line B only");
        expect_rd(0, 8'h20, 0, 1, "R3 edge raw set");
        reg_wr(4, 8'h20);
        expect_rd(0, 8'h00, 0, 0, "R6 edge raw cleared");
        expect_rd(1, 8'h00, 0, 0, "R6 edge pending cleared");

        // collision of a change and a clear
        set_src(2, 1'b1);
        expect_rd(1, 8'h04, 1, 0, "R4 level rise bit2");
        src_in[2] = 1'b0;
        wr_en = 1'b1; wr_addr = 4; wr_data = 8'h04;
        @(negedge clk);
        wr_en = 1'b0;
        expect_rd(1, 8'h04, 1, 0, "R7 change beats clear");
        expect_rd(0, 8'h00, 1, 0, "R7 raw after collision");
        reg_wr(4, 8'h04);
        expect_rd(1, 8'h00, 0, 0, "R6 cleared after collision");

        // both lines, then enable removal
        reg_wr(3, 8'hF8);
        set_src(3, 1'b1);
        expect_rd(1, 8'h08, 1, 1, "R8 both lines");
        reg_wr(2, 8'h07);
        reg_wr(3, 8'hF0);
        expect_rd(1, 8'h08, 0, 0, "R8 enable off keeps pending");
        reg_wr(4, 8'h08);
        expect_rd(1, 8'h00, 0, 0, "R6 final clear");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule